// File: doc/BRIEF.md
# Triple-Buffered PWM Compare Update

This block keeps five compare values for a PWM generator (duty and carrier-cycle thresholds). Each value moves through three stages: a staging register that software may write at any time, an intermediate holding register, and the live compare register that the PWM counters use. Software updates the staging registers with a simple indexed write port. The intermediate stage is loaded from all five staging registers in one cycle. This batch commit starts only when software writes channel 4, so software writes that channel last, with its old value if it has no new one.

A commit is not carried out while the subcounter-busy input is high. The request is remembered and the batch copy runs in the first cycle in which busy is low. A two-state controller holds this request. In state IDLE, a channel-4 write with busy low copies at once, and a channel-4 write with busy high moves to state HOLD. In state HOLD, the controller stays while busy is high and returns to IDLE when busy goes low, doing the deferred copy on that same edge.

The intermediate registers move into the live compare registers on the counter events chosen by a 2-bit mode select. The choices are crest, trough, both, or none. The live values are always visible on a flat output bus.

Top module: `pwm_cmp_update`

## Requirements
- R1: After reset, all staging, intermediate and compare registers are zero, no commit is pending, and every compare output reads zero.
- R2: A write with index 0 to 4 loads the data into that channel's staging register on the clock edge. This is accepted at any time, whether busy is high or low and whether a commit is pending or not.
- R3: A write to channels 0 to 3 alone never changes the intermediate or compare registers.
- R4: A write to channel 4 while busy is low loads all five intermediate registers on the same edge. The source is the staging values including the data just written to channel 4.
- R5: While busy is high, the intermediate registers do not change. A channel-4 write made while busy is high leaves a commit pending.
- R6: A pending commit is carried out on the edge of the first cycle in which busy is low. It uses the staging contents present at that time, including writes made while the commit was deferred. The pending state then clears.
- R7: Mode encoding: 2'b00 gives no transfer, 2'b01 transfers at crest, 2'b10 transfers at trough, and 2'b11 transfers at both crest and trough. Events that the mode does not select have no effect.
- R8: On a selected event, all five compare registers take the intermediate values. The new values appear on the outputs after that clock edge. Without a selected event, the compare outputs hold.
- R9: When a batch copy and a transfer fall on the same edge, the compare registers take the previous intermediate values. The new values reach the compare registers at the next selected event.
- R10: Writes with index 5, 6 or 7 are ignored and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging-register write strobe |
| wr_idx | input | 3 | Channel index of the write; 4 is the commit channel |
| wr_data | input | 16 | Write data |
| sub_busy | input | 1 | Subcounter running; blocks batch commits |
| crest | input | 1 | Counter crest event pulse |
| trough | input | 1 | Counter trough event pulse |
| xfer_mode | input | 2 | Transfer timing select (see R7) |
| cmp_flat | output | 80 | Live compare values, channel n at bits n*16 +: 16 |

## Verification
The bench drives a behavioural model alongside the design and compares all five outputs on every clock. It also makes directed checks at the points where a faulty design would show.

It writes staging registers and fires events without a commit. A design that leaked those writes forward would change the outputs early. It issues a commit while busy is high and writes another channel before busy falls. A design that dropped the deferred commit, or took a snapshot when the request was made, would show stale values.

Each mode is run against crest and trough pulses, which catches a swapped or inverted decode. Finally, a commit and a crest land on the same edge. A design that bypassed the intermediate stage would expose the new value one event early.

// File: rtl/pwm_upd_pkg.sv
package pwm_upd_pkg;

    typedef enum logic [1:0] {
        XFER_OFF    = 2'b00,
        XFER_CREST  = 2'b01,
        XFER_TROUGH = 2'b10,
        XFER_BOTH   = 2'b11
    } xfer_mode_e;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_HOLD = 1'b1
    } commit_state_e;

endpackage

// File: rtl/pwm_upd_commit.sv
module pwm_upd_commit
    import pwm_upd_pkg::*;
#(
    parameter int IDXW       = 3,
    parameter int COMMIT_IDX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic            sub_busy,
    output logic            copy_now
);

    localparam logic [IDXW-1:0] COMMIT_SEL = IDXW'(COMMIT_IDX);

    commit_state_e state_q, state_d;
    logic          commit_wr;

    assign commit_wr = wr_en && (wr_idx == COMMIT_SEL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE: if (commit_wr && sub_busy) state_d = CS_HOLD;
            CS_HOLD: if (!sub_busy)             state_d = CS_IDLE;
        endcase
    end

    always_comb begin
        copy_now = 1'b0;
        unique case (state_q)
            CS_IDLE: copy_now = commit_wr && !sub_busy;
            CS_HOLD: copy_now = !sub_busy;
        endcase
    end

    AST_DEFER_ENTERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && sub_busy) |=> (state_q == CS_HOLD)); // R5
    AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CS_HOLD && !sub_busy) |=> (state_q == CS_IDLE)); // R6

endmodule

// File: rtl/pwm_upd_timing.sv
module pwm_upd_timing
    import pwm_upd_pkg::*;
(
    input  logic [1:0] xfer_mode,
    input  logic       crest,
    input  logic       trough,
    output logic       xfer_now
);

    xfer_mode_e mode;
    assign mode = xfer_mode_e'(xfer_mode);

    always_comb begin
        xfer_now = 1'b0;
        unique case (mode)
            XFER_OFF:    xfer_now = 1'b0;
            XFER_CREST:  xfer_now = crest;
            XFER_TROUGH: xfer_now = trough;
            XFER_BOTH:   xfer_now = crest || trough;
        endcase
    end

endmodule

// File: rtl/pwm_upd_chan.sv
module pwm_upd_chan #(
    parameter int DW   = 16,
    parameter int IDXW = 3,
    parameter int CH   = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            copy_now,
    input  logic            xfer_now,
    output logic [DW-1:0]   tmp_q,
    output logic [DW-1:0]   cmp_q
);

    localparam logic [IDXW-1:0] MY_IDX = IDXW'(CH);

    logic          hit;
    logic [DW-1:0] stg_q, stg_d;

    assign hit   = wr_en && (wr_idx == MY_IDX);
    assign stg_d = hit ? wr_data : stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
            tmp_q <= '0;
            cmp_q <= '0;
        end else begin
            stg_q <= stg_d;
            if (copy_now) tmp_q <= stg_d;
            if (xfer_now) cmp_q <= tmp_q;
        end
    end

endmodule

// File: rtl/pwm_cmp_update.sv
module pwm_cmp_update
    import pwm_upd_pkg::*;
#(
    parameter int NCH = 5,
    parameter int DW  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NCH+3)-1:0]   wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic                       sub_busy,
    input  logic                       crest,
    input  logic                       trough,
    input  logic [1:0]                 xfer_mode,
    output logic [NCH*DW-1:0]          cmp_flat
);

    localparam int IDXW = $clog2(NCH + 3);

    logic              copy_now;
    logic              xfer_now;
    logic [NCH*DW-1:0] tmp_flat;

    pwm_upd_commit #(.IDXW(IDXW), .COMMIT_IDX(NCH - 1)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .sub_busy (sub_busy),
        .copy_now (copy_now)
    );

    pwm_upd_timing u_timing (
        .xfer_mode (xfer_mode),
        .crest     (crest),
        .trough    (trough),
        .xfer_now  (xfer_now)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_upd_chan #(.DW(DW), .IDXW(IDXW), .CH(i)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_idx   (wr_idx),
            .wr_data  (wr_data),
            .copy_now (copy_now),
            .xfer_now (xfer_now),
            .tmp_q    (tmp_flat[i*DW +: DW]),
            .cmp_q    (cmp_flat[i*DW +: DW])
        );
    end

    AST_BUSY_FREEZES_TMP: assert property (@(posedge clk) disable iff (!rst_n)
        sub_busy |=> $stable(tmp_flat)); // R5
    AST_NO_EVENT_HOLDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_now |=> $stable(cmp_flat)); // R8
    AST_CMP_FROM_OLD_TMP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_now |=> (cmp_flat == $past(tmp_flat))); // R9
    AST_MODE_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_mode == 2'b00) |=> $stable(cmp_flat)); // R7

endmodule

// File: tb/pwm_cmp_update_test.sv
module pwm_cmp_update_test;

    localparam int NCH = 5;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_idx = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              sub_busy = 1'b0;
    logic              crest = 1'b0;
    logic              trough = 1'b0;
    logic [1:0]        xfer_mode = 2'b01;
    logic [NCH*DW-1:0] cmp_flat;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 0;
    string cur_req = "R1";

    logic [DW-1:0] m_buf [NCH];
    logic [DW-1:0] m_tmp [NCH];
    logic [DW-1:0] m_cmp [NCH];
    bit            m_pend;

    always #10 clk = ~clk;

    pwm_cmp_update #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sub_busy(sub_busy), .crest(crest),
        .trough(trough), .xfer_mode(xfer_mode), .cmp_flat(cmp_flat)
    );

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_buf[i] = '0; m_tmp[i] = '0; m_cmp[i] = '0;
            end
            m_pend = 0;
        end else begin
            bit ev;
            ev = (xfer_mode[0] && crest) || (xfer_mode[1] && trough);
            if (ev) for (int i = 0; i < NCH; i++) m_cmp[i] = m_tmp[i];
            if (wr_en && wr_idx < NCH) m_buf[wr_idx] = wr_data;
            if (sub_busy) begin
                if (wr_en && wr_idx == 3'd4) m_pend = 1;
            end else if ((wr_en && wr_idx == 3'd4) || m_pend) begin
                for (int i = 0; i < NCH; i++) m_tmp[i] = m_buf[i];
                m_pend = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NCH; i++) begin
                tests++;
                if (cmp_flat[i*DW +: DW] !== m_cmp[i]) begin
                    fails++;
                    $display("FAIL %s model ch%0d actual %h expected %h",
                             cur_req, i, cmp_flat[i*DW +: DW], m_cmp[i]);
                end
            end
        end
    end

    task automatic chk(input int ch, input logic [DW-1:0] exp, input string tag);
        tests++;
        if (cmp_flat[ch*DW +: DW] !== exp) begin
            fails++;
            $display("FAIL %s ch%0d actual %h expected %h",
                     tag, ch, cmp_flat[ch*DW +: DW], exp);
        end
    endtask

    task automatic step(input logic we, input int idx, input logic [DW-1:0] d,
                        input logic cr, input logic tr);
        wr_en = we; wr_idx = idx[2:0]; wr_data = d; crest = cr; trough = tr;
        @(negedge clk);
        wr_en = 1'b0; crest = 1'b0; trough = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < NCH; i++) chk(i, 16'h0000, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) chk(i, 16'h0000, "R1");

        // R3: staging writes alone do not propagate
        cur_req = "R3";
        for (int i = 0; i < 4; i++) step(1, i, 16'h1000 + 16'(i), 0, 0);
        step(0, 0, 0, 1, 0);
        chk(0, 16'h0000, "R3");
        // R4 / R8: commit then crest
        cur_req = "R4";
        step(1, 4, 16'h1004, 0, 0);
        chk(4, 16'h0000, "R8");
        step(0, 0, 0, 1, 0);
        for (int i = 0; i < NCH; i++) chk(i, 16'h1000 + 16'(i), "R4");
        cur_req = "R3";
        step(1, 0, 16'h2000, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(0, 16'h1000, "R3");

        // R10: out-of-range index ignored
        cur_req = "R10";
        step(1, 6, 16'hDEAD, 0, 0);
        step(1, 0, 16'h1000, 0, 0);
        step(1, 4, 16'h1004, 0, 0);
        step(0, 0, 0, 1, 0);
        for (int i = 0; i < NCH; i++) chk(i, 16'h1000 + 16'(i), "R10");

        // R5 / R6 / R2: deferral while busy
        cur_req = "R5";
        sub_busy = 1'b1;
        step(1, 1, 16'h3001, 0, 0);
        step(1, 4, 16'h1004, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(1, 16'h1001, "R5");
        step(1, 2, 16'h3002, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(2, 16'h1002, "R2");
        cur_req = "R6";
        sub_busy = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(1, 16'h3001, "R6");
        chk(2, 16'h3002, "R6");

        // R7: mode decode
        cur_req = "R7";
        xfer_mode = 2'b00;
        step(1, 0, 16'h4000, 0, 0);
        step(1, 4, 16'h1004, 0, 0);
        step(0, 0, 0, 1, 1);
        chk(0, 16'h1000, "R7");
        xfer_mode = 2'b10;
        step(0, 0, 0, 1, 0);
        chk(0, 16'h1000, "R7");
        step(0, 0, 0, 0, 1);
        chk(0, 16'h4000, "R7");
        xfer_mode = 2'b11;
        step(1, 0, 16'h5000, 0, 0);
        step(1, 4, 16'h1004, 0, 0);
        step(0, 0, 0, 1, 0);
        chk(0, 16'h5000, "R7");
        step(1, 0, 16'h6000, 0, 0);
        step(1, 4, 16'h1004, 0, 0);
        step(0, 0, 0, 0, 1);
        chk(0, 16'h6000, "R7");

        // R9: copy and transfer on the same edge
        cur_req = "R9";
        xfer_mode = 2'b01;
        step(1, 0, 16'h7000, 0, 0);
        step(1, 4, 16'h7004, 1, 0);
        chk(0, 16'h6000, "R9");
        chk(4, 16'h1004, "R9");
        step(0, 0, 0, 1, 0);
        chk(0, 16'h7000, "R9");
        chk(4, 16'h7004, "R9");

        step(0, 0, 0, 0, 0);
        finish_run();
    end

endmodule